// File: doc/BRIEF.md
# Clear-to-Send Transmit Gate

This block decides whether a serial transmitter may start its next character. The decision follows an active-low permission pin driven by the remote receiver. A control bit chooses which of two such pins is watched: the clear-to-send line or the data-set-ready line. Both pins pass through a synchronizer before any decision is taken. The selected level then drives a transmit-permit output. A character that is already on the wire is never cut short. When the pin rises while a character is in flight, the permit drops only when the transmitter reports that the stop bit has left the shift register. When the pin returns low, the permit comes back without software action.

The block also raises a sticky flag when the selected pin changes level. This needs two enables: a per-event enable bit, and an extended-feature unlock bit that must also be set. A one-cycle clear pulse removes the flag. This pulse stands for a read of the status register.

The shift register, the baud timing and the holding FIFO are outside this block. The transmitter samples `tx_permit` before it starts each new character.

Top module: `txfc_ctrl`

## Requirements
- R1: After reset, `tx_permit` is 1 and `edge_irq` is 0.
- R2: While `flow_auto_en` is 0, `tx_permit` is 1 one cycle later, whatever the level of either pin.
- R3: With `flow_auto_en` at 1 and `tx_busy` at 0, a rise of the selected pin drops `tx_permit` at the third rising clock edge after the change. Two of those edges are synchronizer stages. `tx_permit` is still 1 after the second edge.
- R4: With `flow_auto_en` at 1, a fall of the selected pin to 0 restores `tx_permit` to 1 at the third rising clock edge after the change.
- R5: While `tx_busy` is 1, a high selected pin does not drop `tx_permit`. It drops at the clock edge that samples `tx_stop_done` at 1.
- R6: `flow_src_sel` = 0 watches `cts_n`. `flow_src_sel` = 1 watches `dsr_n`. The pin that is not selected has no effect on `tx_permit` or `edge_irq`.
- R7: When `feat_unlock` and `edge_irq_en` are both 1, either direction of transition on the selected pin sets `edge_irq`. The flag sets at the third rising edge after the pin change.
- R8: `edge_irq` stays 1 until a cycle with `irq_clr` at 1. It reads 0 after that clock edge, unless a new transition arrives in the same cycle.
- R9: If `feat_unlock` or `edge_irq_en` is 0, pin transitions do not set `edge_irq`.
- R10: Changing `flow_src_sel` does not by itself set `edge_irq`, even when the two pins sit at different levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_n | input | 1 | Remote clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Remote data-set-ready pin, active low, asynchronous |
| flow_auto_en | input | 1 | 1 enables automatic pin-based gating |
| flow_src_sel | input | 1 | 0 watches cts_n, 1 watches dsr_n |
| feat_unlock | input | 1 | Extended-feature unlock; required for the edge interrupt |
| edge_irq_en | input | 1 | Enables the pin-transition interrupt |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_stop_done | input | 1 | One-cycle strobe: the stop bit has been shifted out |
| irq_clr | input | 1 | One-cycle clear of the edge flag |
| tx_permit | output | 1 | 1 allows the transmitter to start a new character |
| edge_irq | output | 1 | Sticky pin-transition flag |

## Verification
The embedded properties check several rules on every cycle. Disabled gating always opens the permit on the next cycle. A low pin always reopens it. A busy transmitter with no stop strobe never loses an open permit. The flag never clears without a clear pulse, and never sets while the interrupt is not armed. The bench scenarios are needed for the rest. They show the exact three-edge latency through the synchronizer, and that the deselected pin is ignored. They also show that a rise held across a character takes effect at the stop strobe, and that switching sources raises no spurious flag.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
  localparam int unsigned NUM_PINS    = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    SRC_CTS = 1'b0,
    SRC_DSR = 1'b1
  } src_e;

  typedef enum logic {
    GATE_OPEN = 1'b0,
    GATE_HELD = 1'b1
  } gate_e;
endpackage

// File: rtl/txfc_sync.sv
module txfc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  // Pins reset to their inactive (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/txfc_gate.sv
module txfc_gate
  import txfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic stop_lvl,
  input  logic busy,
  input  logic stop_done,
  output logic permit
);
  gate_e state_q, state_d;
  logic  state_en;

  always_comb begin
    state_d = state_q;
    if (!auto_en) begin
      state_d = GATE_OPEN;
    end else if (!stop_lvl) begin
      state_d = GATE_OPEN;
    end else if (!busy || stop_done) begin
      state_d = GATE_HELD;
    end
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= GATE_OPEN;
    else if (state_en) state_q <= state_d;
  end

  assign permit = (state_q == GATE_OPEN);

  // R2: gating disabled opens the permit
  a_r2_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> permit);
  // R4: a low synchronized pin reopens the permit
  a_r4_low_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !stop_lvl) |=> permit);
  // R5: no stop in the middle of a character
  a_r5_no_midframe_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_done && permit) |=> permit);
endmodule

// File: rtl/txfc_edge_irq.sv
module txfc_edge_irq #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [SEL_W-1:0] sel,
  input  logic             arm,
  input  logic             clr,
  output logic             flag
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edges;
  logic             hit;
  logic             flag_q, flag_d;

  // Per-pin history, so a source switch is never seen as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign edges = lvl ^ prev_q;
  assign hit   = arm && edges[sel];

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R8: flag is sticky until a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R9: an unarmed interrupt never sets
  a_r9_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !flag) |=> !flag);
endmodule

// File: rtl/txfc_ctrl.sv
module txfc_ctrl
  import txfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic dsr_n,
  input  logic flow_auto_en,
  input  logic flow_src_sel,
  input  logic feat_unlock,
  input  logic edge_irq_en,
  input  logic tx_busy,
  input  logic tx_stop_done,
  input  logic irq_clr,
  output logic tx_permit,
  output logic edge_irq
);
  localparam int unsigned SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [1:0]          rst_pipe_q;
  logic                rst_int_n;
  logic [NUM_PINS-1:0] pin_raw;
  logic [NUM_PINS-1:0] pin_sync;
  logic [SEL_W-1:0]    sel_idx;
  logic                stop_lvl;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign pin_raw[SRC_CTS] = cts_n;
  assign pin_raw[SRC_DSR] = dsr_n;
  assign sel_idx          = SEL_W'(flow_src_sel);

  txfc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pin_raw),
    .dout  (pin_sync)
  );

  assign stop_lvl = pin_sync[sel_idx];

  txfc_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .auto_en   (flow_auto_en),
    .stop_lvl  (stop_lvl),
    .busy      (tx_busy),
    .stop_done (tx_stop_done),
    .permit    (tx_permit)
  );

  txfc_edge_irq #(.WIDTH(NUM_PINS), .SEL_W(SEL_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl   (pin_sync),
    .sel   (sel_idx),
    .arm   (feat_unlock && edge_irq_en),
    .clr   (irq_clr),
    .flag  (edge_irq)
  );

  // R1: reset leaves the gate open and the flag clear
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_int_n |=> (tx_permit && !edge_irq));
endmodule

// File: tb/sim_txfc_ctrl.sv
module sim_txfc_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, cts_n, dsr_n, flow_auto_en, flow_src_sel;
  logic feat_unlock, edge_irq_en, tx_busy, tx_stop_done, irq_clr;
  logic tx_permit, edge_irq;

  always #(CLK_P/2) clk = ~clk;

  txfc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n),
    .flow_auto_en(flow_auto_en), .flow_src_sel(flow_src_sel),
    .feat_unlock(feat_unlock), .edge_irq_en(edge_irq_en),
    .tx_busy(tx_busy), .tx_stop_done(tx_stop_done), .irq_clr(irq_clr),
    .tx_permit(tx_permit), .edge_irq(edge_irq)
  );

  typedef struct {
    int    due;
    bit    chk_p;
    bit    p;
    bit    chk_i;
    bit    i;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  // Driver side: expected value due a number of rising edges from now
  task automatic exp_p(int dly, bit v, string tag);
    q.push_back('{cyc + dly, 1'b1, v, 1'b0, 1'b0, tag});
  endtask
  task automatic exp_i(int dly, bit v, string tag);
    q.push_back('{cyc + dly, 1'b0, 1'b0, 1'b1, v, tag});
  endtask
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: sample a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_P/4);
      for (int k = q.size() - 1; k >= 0; k--) begin
        if (q[k].due <= cyc) begin
          if (q[k].chk_p) begin
            checks++;
            if (q[k].due != cyc || tx_permit !== q[k].p) begin
              failures++;
              $display("FAIL %s tx_permit actual=%b expected=%b cyc=%0d", q[k].tag, tx_permit, q[k].p, cyc);
            end
          end
          if (q[k].chk_i) begin
            checks++;
            if (q[k].due != cyc || edge_irq !== q[k].i) begin
              failures++;
              $display("FAIL %s edge_irq actual=%b expected=%b cyc=%0d", q[k].tag, edge_irq, q[k].i, cyc);
            end
          end
          q.delete(k);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cts_n = 1; dsr_n = 1; flow_auto_en = 0; flow_src_sel = 0;
    feat_unlock = 0; edge_irq_en = 0; tx_busy = 0; tx_stop_done = 0; irq_clr = 0;
    step(3);
    rst_n = 1;
    step(4);
    exp_p(1, 1, "R1"); exp_i(1, 0, "R1");
    step(2);

    // R2: gating disabled, pin activity ignored
    cts_n = 0; exp_p(3, 1, "R2"); step(4);
    cts_n = 1; exp_p(3, 1, "R2"); exp_p(4, 1, "R2"); exp_i(4, 0, "R9"); step(5);

    // R3: enable while pin high and idle -> hold next edge
    flow_auto_en = 1; exp_p(1, 0, "R3"); step(2);
    cts_n = 0; exp_p(2, 0, "R4"); exp_p(3, 1, "R4"); step(4);
    cts_n = 1; exp_p(2, 1, "R3"); exp_p(3, 0, "R3"); step(4);
    cts_n = 0; exp_p(3, 1, "R4"); step(4);

    // R5: deferred stop while a character is in flight
    tx_busy = 1; step(1);
    cts_n = 1;
    exp_p(3, 1, "R5"); exp_p(4, 1, "R5"); exp_p(5, 1, "R5"); exp_p(6, 1, "R5");
    step(6);
    tx_stop_done = 1; exp_p(1, 0, "R5"); step(1);
    tx_stop_done = 0; tx_busy = 0; exp_p(1, 0, "R5"); step(2);
    cts_n = 0; exp_p(3, 1, "R4"); step(4);

    // R6: select the data-set-ready pin
    dsr_n = 0; step(4);
    flow_src_sel = 1; exp_p(1, 1, "R6"); step(1);
    cts_n = 1; exp_p(3, 1, "R6"); exp_p(4, 1, "R6"); step(5);
    dsr_n = 1; exp_p(3, 0, "R6"); step(4);
    dsr_n = 0; exp_p(3, 1, "R6"); step(4);
    cts_n = 0; exp_p(3, 1, "R6"); step(4);

    // R7 / R8: armed edge flag, both directions, sticky until clear
    feat_unlock = 1; edge_irq_en = 1; step(1);
    dsr_n = 1; exp_i(2, 0, "R7"); exp_i(3, 1, "R7"); exp_p(3, 0, "R7"); step(5);
    exp_i(1, 1, "R8"); step(1);
    irq_clr = 1; exp_i(1, 0, "R8"); step(1);
    irq_clr = 0; exp_i(2, 0, "R8");
    dsr_n = 0; exp_i(3, 1, "R7"); exp_p(3, 1, "R7"); step(4);
    irq_clr = 1; exp_i(1, 0, "R8"); step(1);
    irq_clr = 0;

    // R10: deselected pin edges and source switch raise no flag
    cts_n = 1; exp_i(3, 0, "R6"); exp_i(4, 0, "R6"); step(5);
    flow_src_sel = 0; exp_i(1, 0, "R10"); exp_i(2, 0, "R10"); exp_p(1, 0, "R10"); step(3);
    cts_n = 0; exp_p(3, 1, "R4"); exp_i(3, 1, "R7"); step(4);
    irq_clr = 1; exp_i(1, 0, "R8"); step(1);
    irq_clr = 0;

    // R9: either enable missing keeps the flag quiet
    feat_unlock = 0; step(1);
    cts_n = 1; exp_i(3, 0, "R9"); exp_p(3, 0, "R3"); exp_i(5, 0, "R9"); step(6);
    feat_unlock = 1; edge_irq_en = 0; step(1);
    cts_n = 0; exp_i(3, 0, "R9"); exp_p(3, 1, "R4"); exp_i(5, 0, "R9"); step(6);

    // R2: disabling while held reopens at once
    cts_n = 1; exp_p(3, 0, "R3"); step(4);
    flow_auto_en = 0; exp_p(1, 1, "R2"); step(3);

    while (q.size() != 0) step(1);
    step(1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule